// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block merges the interrupt sources of a small controller board into the three-bit, active-low interrupt priority level that a 68000-family processor samples. An abort line, the SCSI and floppy requests, and the timer and port requests of a parallel/timer device arrive asynchronously and are synchronized. The DMA controller instead reports through one-cycle synchronous strobes (completion or error), each carrying a flag and an 8-bit vector. The highest-numbered pending source drives the level. Level 7 is the non-maskable port source, used for watchdog expiry or a bus trigger. Level 6 has no source.

During an interrupt-acknowledge cycle the block answers in one of three ways. It can request an autovector. It can drive an 8-bit vector with a valid strobe. For the timer and port levels it hands the cycle to the parallel/timer device and forwards that device's vector. A strap input selects whether the DMA level is autovectored or returns the vector latched from the most recent DMA event. An acknowledge for a level with nothing pending returns the spurious-interrupt vector instead of stalling the processor.

The acknowledge interface is a held-request handshake. The processor raises `iack_req` with a stable `iack_lvl` and holds both until the block pulses `avec` or `vec_valid` for one cycle. It then lowers `iack_req` for at least one cycle before the next acknowledge. The hand-off to the parallel/timer device works the same way: `pit_iack` stays high until that device pulses `pit_vec_valid`.

Top module: `irq_level_enc`

## Requirements
- R1: A change on any asynchronous request input appears on `ipl_n` after exactly three rising clock edges: two synchronizer stages plus the level register.
- R2: `ipl_n` is the bitwise inverse of the highest pending level. The level assignment is abort=1, DMA=2, SCSI=3, floppy=4, timer=5 and port=7. With nothing pending `ipl_n` is 3'b111, and it is 3'b111 after reset.
- R3: Level 6 is never presented: `ipl_n` never equals 3'b001.
- R4: A DMA strobe (`dma_done_stb` or `dma_err_stb`) with `dma_flag`=1 sets the DMA pending state and captures `dma_vec`. A later such strobe replaces the captured vector. A strobe with `dma_flag`=0 clears the pending state. The pending state reaches `ipl_n` two edges after the strobe.
- R5: An acknowledge at level 2 while DMA is pending clears the DMA pending state. With `vec_strap`=1 it returns the captured vector on `vec_out` with `vec_valid`. With `vec_strap`=0 it pulses `avec`.
- R6: An acknowledge at level 1, 3 or 4 while that source is pending pulses `avec`.
- R7: An acknowledge at level 5 or 7 while that source is pending raises `pit_iack` until `pit_vec_valid` is seen. It then returns `pit_vec` on `vec_out` with `vec_valid` one cycle later, and `pit_iack` falls.
- R8: An acknowledge at level 0 or 6, or at any level with no pending source, returns vector 8'h18 with `vec_valid`.
- R9: `ipl_n` does not change from the cycle an acknowledge is accepted until the cycle after `iack_req` is seen low.
- R10: Each acknowledge produces exactly one one-cycle pulse, on either `avec` or `vec_valid` but never both. For directly answered levels the pulse appears one cycle after `iack_req` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_req | input | 1 | Abort request, asynchronous level |
| scsi_req | input | 1 | SCSI controller request, asynchronous level |
| fdc_req | input | 1 | Floppy controller request, asynchronous level |
| tmr_req | input | 1 | Parallel/timer device timer request, asynchronous level |
| port_req | input | 1 | Parallel/timer device port request (non-maskable), asynchronous level |
| dma_done_stb | input | 1 | DMA completion event, one-cycle synchronous strobe |
| dma_err_stb | input | 1 | DMA error event, one-cycle synchronous strobe |
| dma_flag | input | 1 | Event flag sampled with a DMA strobe; 1 sets, 0 clears |
| dma_vec | input | 8 | Vector sampled with a DMA strobe |
| vec_strap | input | 1 | 1: DMA level returns its vector; 0: DMA level autovectored |
| iack_req | input | 1 | Interrupt-acknowledge request, held until a response |
| iack_lvl | input | 3 | Level being acknowledged |
| pit_vec_valid | input | 1 | Parallel/timer device vector is valid |
| pit_vec | input | 8 | Vector from the parallel/timer device |
| ipl_n | output | 3 | Active-low encoded priority level |
| avec | output | 1 | Autovector request pulse |
| vec_out | output | 8 | Vector returned for the acknowledge |
| vec_valid | output | 1 | `vec_out` valid pulse |
| pit_iack | output | 1 | Acknowledge handed to the parallel/timer device |

## Verification
The assertions assume the processor keeps `iack_req` and `iack_lvl` stable until it sees a response, then releases the request for at least one cycle. They also assume DMA strobes are single-cycle synchronous pulses and that `pit_vec_valid` rises only while `pit_iack` is high. The stimulus follows these rules. A task drives each acknowledge, holds it until a response appears, and answers the parallel/timer hand-off only after `pit_iack` has been observed. DMA strobes and request-line changes are applied on falling edges, outside acknowledge windows, except where the level freeze is being tested on purpose.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = 3;
  localparam int NUM_ASYNC = 5;

  localparam int LVL_ABORT = 1;
  localparam int LVL_DMA   = 2;
  localparam int LVL_SCSI  = 3;
  localparam int LVL_FDC   = 4;
  localparam int LVL_TMR   = 5;
  localparam int LVL_PORT  = 7;

  // order of bits inside the synchronizer bus
  localparam int SY_ABORT = 0;
  localparam int SY_SCSI  = 1;
  localparam int SY_FDC   = 2;
  localparam int SY_TMR   = 3;
  localparam int SY_PORT  = 4;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_PIT  = 2'd1,
    ACK_DONE = 2'd2
  } ack_st_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_dma_latch.sv
module irq_dma_latch #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             flag,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             clr,
  output logic             pend,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
    end else if (evt) begin
      pend <= flag;
      if (flag) vec <= vec_in;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end

  AST_DMA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && flag) |=> (pend && vec == $past(vec_in)));  // R4
  AST_DMA_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !flag) |=> !pend);  // R4
  AST_DMA_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend);  // R5
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_enc_pkg::*;
#(
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iack_req,
  input  logic [LVL_W-1:0]   iack_lvl,
  input  logic [NUM_LVL-1:0] pend,
  input  logic               strap,
  input  logic [VEC_W-1:0]   dma_vec,
  input  logic               pit_vec_valid,
  input  logic [VEC_W-1:0]   pit_vec,
  output logic               avec,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out,
  output logic               pit_iack,
  output logic               dma_clr,
  output logic               busy
);
  ack_st_t st;
  logic    take, lvl_live, lvl_dev, lvl_dma;

  assign take     = (st == ACK_IDLE) && iack_req;
  assign lvl_live = pend[iack_lvl];
  assign lvl_dev  = (iack_lvl == LVL_W'(LVL_TMR)) || (iack_lvl == LVL_W'(LVL_PORT));
  assign lvl_dma  = (iack_lvl == LVL_W'(LVL_DMA));
  assign dma_clr  = take && lvl_dma && lvl_live;
  assign pit_iack = (st == ACK_PIT);
  assign busy     = (st != ACK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ACK_IDLE;
      avec      <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      avec      <= 1'b0;
      vec_valid <= 1'b0;
      unique case (st)
        ACK_IDLE: if (iack_req) begin
          st <= ACK_DONE;
          if (!lvl_live) begin
            vec_valid <= 1'b1;
            vec_out   <= SPUR_VEC;
          end else if (lvl_dev) begin
            st <= ACK_PIT;
          end else if (lvl_dma && strap) begin
            vec_valid <= 1'b1;
            vec_out   <= dma_vec;
          end else begin
            avec <= 1'b1;
          end
        end
        ACK_PIT: if (pit_vec_valid) begin
          vec_valid <= 1'b1;
          vec_out   <= pit_vec;
          st        <= ACK_DONE;
        end
        ACK_DONE: if (!iack_req) st <= ACK_IDLE;
        default: st <= ACK_IDLE;
      endcase
    end
  end

  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(avec && vec_valid));  // R10
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (avec || vec_valid) |-> $past(iack_req));  // R10
  AST_PIT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (pit_iack && pit_vec_valid) |=> (vec_valid && vec_out == $past(pit_vec) && !pit_iack));  // R7
  AST_SPUR_L6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && iack_lvl == 3'd6) |=> (vec_valid && vec_out == SPUR_VEC));  // R8
  AST_AVEC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && iack_lvl == LVL_W'(LVL_ABORT) && pend[LVL_ABORT]) |=> avec);  // R6
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_enc_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_req,
  input  logic             scsi_req,
  input  logic             fdc_req,
  input  logic             tmr_req,
  input  logic             port_req,
  input  logic             dma_done_stb,
  input  logic             dma_err_stb,
  input  logic             dma_flag,
  input  logic [VEC_W-1:0] dma_vec,
  input  logic             vec_strap,
  input  logic             iack_req,
  input  logic [LVL_W-1:0] iack_lvl,
  input  logic             pit_vec_valid,
  input  logic [VEC_W-1:0] pit_vec,
  output logic [LVL_W-1:0] ipl_n,
  output logic             avec,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid,
  output logic             pit_iack
);
  logic [NUM_ASYNC-1:0] raw, sy;
  logic                 dma_pend, dma_clr, ack_busy;
  logic [VEC_W-1:0]     dma_vec_q;
  logic [NUM_LVL-1:0]   pend;
  logic [LVL_W-1:0]     top_lvl;

  always_comb begin
    raw           = '0;
    raw[SY_ABORT] = abort_req;
    raw[SY_SCSI]  = scsi_req;
    raw[SY_FDC]   = fdc_req;
    raw[SY_TMR]   = tmr_req;
    raw[SY_PORT]  = port_req;
  end

  irq_sync #(.W(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sy)
  );

  irq_dma_latch #(.VEC_W(VEC_W)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .evt(dma_done_stb | dma_err_stb), .flag(dma_flag), .vec_in(dma_vec),
    .clr(dma_clr), .pend(dma_pend), .vec(dma_vec_q)
  );

  always_comb begin
    pend            = '0;
    pend[LVL_ABORT] = sy[SY_ABORT];
    pend[LVL_DMA]   = dma_pend;
    pend[LVL_SCSI]  = sy[SY_SCSI];
    pend[LVL_FDC]   = sy[SY_FDC];
    pend[LVL_TMR]   = sy[SY_TMR];
    pend[LVL_PORT]  = sy[SY_PORT];
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 1; i < NUM_LVL; i++) if (pend[i]) top_lvl = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ipl_n <= '1;
    else if (!ack_busy && !iack_req) ipl_n <= ~top_lvl;
  end

  irq_ack_ctrl #(.VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .iack_req(iack_req), .iack_lvl(iack_lvl), .pend(pend),
    .strap(vec_strap), .dma_vec(dma_vec_q),
    .pit_vec_valid(pit_vec_valid), .pit_vec(pit_vec),
    .avec(avec), .vec_valid(vec_valid), .vec_out(vec_out),
    .pit_iack(pit_iack), .dma_clr(dma_clr), .busy(ack_busy)
  );

  AST_NO_LEVEL6: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_n != 3'b001);  // R3
  AST_IPL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_req || ack_busy) |=> $stable(ipl_n));  // R9
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_req && !ack_busy && pend == '0) |=> ipl_n == 3'b111);  // R2
endmodule

// File: tb/sim_irq_level_enc.sv
`timescale 1ns/1ps
module sim_irq_level_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_req = 0, scsi_req = 0, fdc_req = 0, tmr_req = 0, port_req = 0;
  logic dma_done_stb = 0, dma_err_stb = 0, dma_flag = 0;
  logic [7:0] dma_vec = 0;
  logic vec_strap = 0, iack_req = 0, pit_vec_valid = 0;
  logic [2:0] iack_lvl = 0;
  logic [7:0] pit_vec = 0;
  logic [2:0] ipl_n;
  logic avec, vec_valid, pit_iack;
  logic [7:0] vec_out;

  always #2.5 clk = ~clk;

  irq_level_enc u0 (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .scsi_req(scsi_req),
    .fdc_req(fdc_req), .tmr_req(tmr_req), .port_req(port_req),
    .dma_done_stb(dma_done_stb), .dma_err_stb(dma_err_stb), .dma_flag(dma_flag),
    .dma_vec(dma_vec), .vec_strap(vec_strap), .iack_req(iack_req), .iack_lvl(iack_lvl),
    .pit_vec_valid(pit_vec_valid), .pit_vec(pit_vec), .ipl_n(ipl_n), .avec(avec),
    .vec_out(vec_out), .vec_valid(vec_valid), .pit_iack(pit_iack)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit run_cmp = 0;

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endfunction

  // behavioural reference model, updated on every rising edge
  int m_s1 = 0, m_s2 = 0, m_dp = 0, m_dv = 0, m_st = 0, m_lvl = 0;
  int m_av = 0, m_vv = 0, m_vo = 0, m_pi = 0;
  always @(posedge clk) begin : model
    int pl[8];
    int top, nst, nav, nvv, nvo, clr, l;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_dp = 0; m_dv = 0; m_st = 0; m_lvl = 0;
      m_av = 0; m_vv = 0; m_vo = 0; m_pi = 0;
    end else begin
      pl[0] = 0; pl[1] = m_s2 & 1; pl[2] = m_dp; pl[3] = (m_s2 >> 1) & 1;
      pl[4] = (m_s2 >> 2) & 1; pl[5] = (m_s2 >> 3) & 1; pl[6] = 0; pl[7] = (m_s2 >> 4) & 1;
      top = 0;
      for (int i = 1; i < 8; i++) if (pl[i] != 0) top = i;
      nst = m_st; nav = 0; nvv = 0; nvo = m_vo; clr = 0;
      if (m_st == 0) begin
        if (iack_req) begin
          l = int'(iack_lvl);
          nst = 2;
          if (pl[l] == 0) begin nvv = 1; nvo = 'h18; end
          else if (l == 5 || l == 7) nst = 1;
          else if (l == 2) begin
            clr = 1;
            if (vec_strap) begin nvv = 1; nvo = m_dv; end else nav = 1;
          end else nav = 1;
        end else m_lvl = top;
      end else if (m_st == 1) begin
        if (pit_vec_valid) begin nvv = 1; nvo = int'(pit_vec); nst = 2; end
      end else if (!iack_req) nst = 0;
      if (dma_done_stb || dma_err_stb) begin
        if (dma_flag) begin m_dp = 1; m_dv = int'(dma_vec); end else m_dp = 0;
      end else if (clr != 0) m_dp = 0;
      m_st = nst; m_av = nav; m_vv = nvv; m_vo = nvo; m_pi = (nst == 1) ? 1 : 0;
      m_s2 = m_s1;
      m_s1 = {port_req, tmr_req, fdc_req, scsi_req, abort_req};
    end
  end

  always @(negedge clk) if (rst_n && run_cmp) begin
    chk("R2 R9 ipl_n vs model", int'(ipl_n), (~m_lvl) & 7);
    chk("R3 level 6 presented", (ipl_n == 3'b001) ? 1 : 0, 0);
    chk("R10 avec vs model", int'(avec), m_av);
    chk("R10 vec_valid vs model", int'(vec_valid), m_vv);
    chk("R7 pit_iack vs model", int'(pit_iack), m_pi);
    if (m_vv != 0) chk("R8 vec_out vs model", int'(vec_out), m_vo);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack(input int lvl, input int pv, output int got_av,
                        output int got_vec, output int lat, output int ipl_seen);
    int n = 0;
    iack_req = 1; iack_lvl = 3'(lvl);
    got_av = 0; got_vec = -1; lat = 0; ipl_seen = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pit_vec_valid = 0;
      lat++;
      if (avec) begin got_av = 1; ipl_seen = int'(ipl_n); break; end
      if (vec_valid) begin got_vec = int'(vec_out); ipl_seen = int'(ipl_n); break; end
      if (pit_iack) begin
        n++;
        if (n == 2) begin pit_vec_valid = 1; pit_vec = 8'(pv); end
      end
    end
    pit_vec_valid = 0;
    iack_req = 0;
    @(negedge clk);
  endtask

  task automatic dma_evt(input bit err, input bit flg, input int v);
    dma_done_stb = !err; dma_err_stb = err; dma_flag = flg; dma_vec = 8'(v);
    @(negedge clk);
    dma_done_stb = 0; dma_err_stb = 0; dma_flag = 0;
  endtask

  initial begin
    int av, vc, lat, ips, pulses;
    waitn(4);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    chk("R2 reset level", int'(ipl_n), 7);
    chk("R10 reset avec", int'(avec), 0);

    // R1: three-edge latency from an asynchronous request
    fdc_req = 1;
    waitn(2);
    chk("R1 not yet visible", int'(ipl_n), 7);
    waitn(1);
    chk("R1 floppy level 4", int'(ipl_n), 3'b011);

    // R2: priority among several sources
    abort_req = 1; scsi_req = 1;
    waitn(4);
    chk("R2 level 4 over 1 and 3", int'(ipl_n), 3'b011);
    tmr_req = 1;
    waitn(4);
    chk("R2 timer level 5", int'(ipl_n), 3'b010);
    port_req = 1;
    waitn(4);
    chk("R2 port level 7", int'(ipl_n), 3'b000);

    // R7 + R9: port acknowledge while the port request falls
    port_req = 0;
    do_ack(7, 'h47, av, vc, lat, ips);
    chk("R7 port vector forwarded", vc, 'h47);
    chk("R9 level frozen during ack", ips, 3'b000);
    waitn(3);
    chk("R9 level resumes after ack", int'(ipl_n), 3'b010);

    do_ack(5, 'h55, av, vc, lat, ips);
    chk("R7 timer vector forwarded", vc, 'h55);

    // R6 autovectored levels, R10 latency
    do_ack(4, 0, av, vc, lat, ips);
    chk("R6 floppy autovector", av, 1);
    chk("R10 response one cycle after request", lat, 1);
    do_ack(1, 0, av, vc, lat, ips);
    chk("R6 abort autovector", av, 1);
    do_ack(3, 0, av, vc, lat, ips);
    chk("R6 scsi autovector", av, 1);

    // R10: a held request yields a single pulse
    pulses = 0;
    iack_req = 1; iack_lvl = 3'd1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (avec || vec_valid) pulses++;
    end
    iack_req = 0;
    @(negedge clk);
    chk("R10 single pulse per request", pulses, 1);

    // R8 spurious
    scsi_req = 0;
    waitn(3);
    do_ack(3, 0, av, vc, lat, ips);
    chk("R8 scsi not pending gives 18", vc, 'h18);
    do_ack(6, 0, av, vc, lat, ips);
    chk("R8 level 6 gives 18", vc, 'h18);
    do_ack(0, 0, av, vc, lat, ips);
    chk("R8 level 0 gives 18", vc, 'h18);

    // DMA level
    abort_req = 0; fdc_req = 0; tmr_req = 0;
    waitn(4);
    chk("R2 nothing pending", int'(ipl_n), 7);
    vec_strap = 0;
    dma_evt(0, 1, 'h64);
    chk("R4 not yet visible", int'(ipl_n), 7);
    waitn(1);
    chk("R4 dma level 2", int'(ipl_n), 3'b101);
    do_ack(2, 0, av, vc, lat, ips);
    chk("R5 strap off autovector", av, 1);
    waitn(2);
    chk("R5 pending cleared by ack", int'(ipl_n), 7);

    vec_strap = 1;
    dma_evt(1, 1, 'hA9);
    waitn(2);
    do_ack(2, 0, av, vc, lat, ips);
    chk("R5 strap on returns vector", vc, 'hA9);

    dma_evt(0, 1, 'h10);
    dma_evt(1, 1, 'h20);
    waitn(2);
    do_ack(2, 0, av, vc, lat, ips);
    chk("R4 latest vector kept", vc, 'h20);

    dma_evt(0, 1, 'h33);
    dma_evt(1, 0, 'h77);
    waitn(2);
    chk("R4 zero flag clears", int'(ipl_n), 7);
    do_ack(2, 0, av, vc, lat, ips);
    chk("R4 R8 cleared dma spurious", vc, 'h18);

    waitn(4);
    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule